// File: doc/BRIEF.md
# Chained Breakpoint Trigger Matcher

This block holds ten breakpoint triggers and checks every accepted pipeline event against all of them at once. An event is an instruction fetch, a load or a store, and it carries an address and a data word. Each trigger watches exactly one event kind, and that kind is fixed by the trigger's position. Triggers are grouped in fixed pairs: group g is trigger 2g together with trigger 2g+1. A per-pair link turns the pair into a conjunction, so the pair fires only when both members match the same event with the same timing setting.

Triggers are programmed through a write port that is qualified by a valid bit and carries a trigger index plus the settings for that trigger. Events enter on a valid/ready stream. Results leave on a second valid/ready stream, one cycle after the event is accepted. Each result carries the vector of triggers that fired, a combined hit, and the timing and action of the winning trigger. The per-trigger enable pins are level controls without a handshake.

Back-pressure works as follows. The block holds one result. `evt_ready` is high when no result is pending or when the pending result is being taken in the same cycle. A pending result and its fields do not change until `res_ready` is seen high.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every trigger is unprogrammed, and an unprogrammed trigger matches nothing even while its enable is high. After reset `res_valid` is 0 and `evt_ready` is 1.
- R2: A configuration write is applied at the clock edge where `cfg_valid` is high. An event accepted at that same edge is still compared against the old settings, and the next event sees the new ones. A write whose index is 10 or more changes no trigger.
- R3: Match type encoding is 0 = equal, 1 = masked equal, 2 = unsigned greater-or-equal and 3 = unsigned less-than. For masked equal, the trailing ones of the compare value and the zero bit just above them are ignored. Select 0 compares the event address and select 1 compares the event data.
- R4: Event kind encoding is 0 = fetch, 1 = load, 2 = store and 3 = none. Triggers 0, 1, 6 and 8 see fetches, triggers 2, 3 and 7 see stores, and triggers 4, 5 and 9 see loads. A trigger never matches an event of another kind.
- R5: A load trigger with select 1 never matches, whatever the data.
- R6: A trigger whose `trig_en` bit is low never matches, and so it also blocks its linked pair.
- R7: If the chain bit of trigger 2g is set, triggers 2g and 2g+1 fire only together and only when both match. Otherwise each fires on its own match.
- R8: A linked pair whose two members have different timing bits fires neither member.
- R9: The store/store pair (triggers 2 and 3) is never linked, whatever its chain bit.
- R10: `res_hit` is the OR of `res_hitvec`. `res_timing` and `res_action` come from the lowest-numbered trigger that fired, and are 0 when none fired.
- R11: An event is accepted when `evt_valid` and `evt_ready` are both high, and its result appears on the next cycle. While `res_valid` is high and `res_ready` is low, `evt_ready` is low and the result stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Trigger index to write |
| cfg_mtype | input | 2 | Match type (R3) |
| cfg_sel | input | 1 | 0 = compare address, 1 = compare data |
| cfg_timing | input | 1 | 0 = trap on the current instruction, 1 = trap on the next instruction |
| cfg_action | input | 1 | Action bit reported on a hit |
| cfg_chain | input | 1 | Link bit (used from the even member only) |
| cfg_value | input | 64 | Compare value |
| trig_en | input | 10 | Per-trigger enable |
| evt_valid | input | 1 | Event valid |
| evt_ready | output | 1 | Event accepted when high together with valid |
| evt_kind | input | 2 | Event kind (R4) |
| evt_addr | input | 64 | Event address |
| evt_data | input | 64 | Event data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_hitvec | output | 10 | Fired triggers |
| res_hit | output | 1 | Any trigger fired |
| res_timing | output | 1 | Timing of the lowest fired trigger |
| res_action | output | 1 | Action of the lowest fired trigger |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:
- **Linked pairs with one member missing.** A design that checked only the even member would fire on a half match.
- **Linked pairs whose members disagree on timing.** A design that skipped the timing check would report a hit here.
- **The store/store pair with its chain bit set.** A design that honoured that bit would silence trigger 2 when it matches alone.
- **Load triggers that select data.** A design that let these through would fire on a matching data word.
- **Out-of-range write index 10.** A design that truncated the index would overwrite trigger 2.
- **Write landing on the same edge as an event.** A design that forwarded the new settings would report a hit early.
- **Held result under back-pressure.** A design that did not stall would drop the held result or accept a new event while the consumer is stalled.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int VAL_W = 64;

  typedef enum logic [1:0] {
    EV_FETCH = 2'd0,
    EV_LOAD  = 2'd1,
    EV_STORE = 2'd2,
    EV_NONE  = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    MT_EQ    = 2'd0,
    MT_NAPOT = 2'd1,
    MT_GE    = 2'd2,
    MT_LT    = 2'd3
  } match_e;

  typedef struct packed {
    logic             armed;
    match_e           mtype;
    logic             sel;
    logic             timing;
    logic             action;
    logic             chain;
    logic [VAL_W-1:0] value;
  } trig_cfg_t;

  // Fixed event kind watched by each trigger position.
  function automatic logic [1:0] kind_of(input int idx);
    case (idx)
      2, 3, 7: kind_of = EV_STORE;
      4, 5, 9: kind_of = EV_LOAD;
      default: kind_of = EV_FETCH;
    endcase
  endfunction
endpackage

// File: rtl/dbg_trig_cfg_bank.sv
module dbg_trig_cfg_bank
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 10,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [IDX_W-1:0]         wr_idx,
  input  trig_cfg_t                wr_cfg,
  output trig_cfg_t [NUM_TRIG-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_valid) begin
      for (int i = 0; i < NUM_TRIG; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          cfg_q[i]       <= wr_cfg;
          cfg_q[i].armed <= 1'b1;
        end
      end
    end
  end

  // R2: an out-of-range index leaves every trigger untouched
  p_bad_index_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (32'(wr_idx) >= NUM_TRIG)) |=> $stable(cfg_q));
endmodule

// File: rtl/dbg_trig_compare.sv
module dbg_trig_compare
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  trig_cfg_t [NUM_TRIG-1:0] cfg_i,
  input  logic [NUM_TRIG-1:0]      en_i,
  input  logic [1:0]               kind_i,
  input  logic [VAL_W-1:0]         addr_i,
  input  logic [VAL_W-1:0]         data_i,
  output logic [NUM_TRIG-1:0]      match_o
);
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    localparam logic [1:0] KIND = kind_of(i);
    logic [VAL_W-1:0] operand;
    logic [VAL_W-1:0] dont_care;
    logic             cmp_ok;
    logic             kind_ok;

    assign operand   = cfg_i[i].sel ? data_i : addr_i;
    // Trailing ones of the value plus the zero above them are ignored.
    assign dont_care = cfg_i[i].value ^ (cfg_i[i].value + VAL_W'(1));

    always_comb begin
      case (cfg_i[i].mtype)
        MT_EQ:    cmp_ok = (operand == cfg_i[i].value);
        MT_NAPOT: cmp_ok = ((operand | dont_care) == (cfg_i[i].value | dont_care));
        MT_GE:    cmp_ok = (operand >= cfg_i[i].value);
        default:  cmp_ok = (operand <  cfg_i[i].value);
      endcase
    end

    // Data comparison is not available on load triggers.
    assign kind_ok    = (kind_i == KIND) && !((KIND == EV_LOAD) && cfg_i[i].sel);
    assign match_o[i] = cfg_i[i].armed && en_i[i] && kind_ok && cmp_ok;

    // R5: load trigger selecting data never matches
    p_load_data_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((KIND == EV_LOAD) && cfg_i[i].sel) |-> !match_o[i]);
    // R6: disabled trigger never matches
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[i] |-> !match_o[i]);
    // R4: wrong event kind never matches
    p_kind_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i != KIND) |-> !match_o[i]);
  end
endmodule

// File: rtl/dbg_trig_chain.sv
module dbg_trig_chain
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  trig_cfg_t [NUM_TRIG-1:0] cfg_i,
  input  logic [NUM_TRIG-1:0]      match_i,
  output logic [NUM_TRIG-1:0]      fire_o
);
  localparam int NUM_GRP = NUM_TRIG / 2;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
    localparam int A = 2 * g;
    localparam int B = 2 * g + 1;
    localparam bit STORE_PAIR = (kind_of(A) == EV_STORE) && (kind_of(B) == EV_STORE);
    logic linked;
    logic both;

    assign linked = !STORE_PAIR && cfg_i[A].chain;
    assign both   = match_i[A] && match_i[B] && (cfg_i[A].timing == cfg_i[B].timing);

    assign fire_o[A] = linked ? both : match_i[A];
    assign fire_o[B] = linked ? both : match_i[B];

    // R8: linked members with differing timing never fire
    p_timing_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (linked && (cfg_i[A].timing != cfg_i[B].timing)) |-> !(fire_o[A] || fire_o[B]));
    // R7: a linked pair fires only as a whole
    p_pair_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
      linked |-> (fire_o[A] == fire_o[B]));
    // R9: store/store pair always fires on individual matches
    p_store_unlinked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      STORE_PAIR |-> (fire_o[A] == match_i[A]) && (fire_o[B] == match_i[B]));
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int  NUM_TRIG = 10,
  localparam int IDX_W    = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [1:0]          cfg_mtype,
  input  logic                cfg_sel,
  input  logic                cfg_timing,
  input  logic                cfg_action,
  input  logic                cfg_chain,
  input  logic [VAL_W-1:0]    cfg_value,
  input  logic [NUM_TRIG-1:0] trig_en,
  input  logic                evt_valid,
  output logic                evt_ready,
  input  logic [1:0]          evt_kind,
  input  logic [VAL_W-1:0]    evt_addr,
  input  logic [VAL_W-1:0]    evt_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [NUM_TRIG-1:0] res_hitvec,
  output logic                res_hit,
  output logic                res_timing,
  output logic                res_action
);
  trig_cfg_t                wr_cfg;
  trig_cfg_t [NUM_TRIG-1:0] cfg_q;
  logic [NUM_TRIG-1:0]      match;
  logic [NUM_TRIG-1:0]      fire;
  logic                     win_timing;
  logic                     win_action;
  logic                     found;
  logic                     accept;

  always_comb begin
    wr_cfg        = '0;
    wr_cfg.mtype  = match_e'(cfg_mtype);
    wr_cfg.sel    = cfg_sel;
    wr_cfg.timing = cfg_timing;
    wr_cfg.action = cfg_action;
    wr_cfg.chain  = cfg_chain;
    wr_cfg.value  = cfg_value;
  end

  dbg_trig_cfg_bank #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (cfg_valid),
    .wr_idx   (cfg_idx),
    .wr_cfg   (wr_cfg),
    .cfg_q    (cfg_q)
  );

  dbg_trig_compare #(.NUM_TRIG(NUM_TRIG)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg_q),
    .en_i    (trig_en),
    .kind_i  (evt_kind),
    .addr_i  (evt_addr),
    .data_i  (evt_data),
    .match_o (match)
  );

  dbg_trig_chain #(.NUM_TRIG(NUM_TRIG)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg_q),
    .match_i (match),
    .fire_o  (fire)
  );

  // Lowest-numbered fired trigger supplies timing and action.
  always_comb begin
    win_timing = 1'b0;
    win_action = 1'b0;
    found      = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (fire[i] && !found) begin
        found      = 1'b1;
        win_timing = cfg_q[i].timing;
        win_action = cfg_q[i].action;
      end
    end
  end

  assign evt_ready = !res_valid || res_ready;
  assign accept    = evt_valid && evt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hitvec <= '0;
      res_hit    <= 1'b0;
      res_timing <= 1'b0;
      res_action <= 1'b0;
    end else if (accept) begin
      res_valid  <= 1'b1;
      res_hitvec <= fire;
      res_hit    <= found;
      res_timing <= win_timing;
      res_action <= win_action;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  // R11: a stalled result is held and no event is taken
  p_hold_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hitvec) &&
                                   $stable(res_timing) && $stable(res_action)));
  p_no_take_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !evt_ready);
  // R10: combined hit agrees with the vector
  p_hit_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (|res_hitvec)));
  // R10: nothing fired means zero timing and action
  p_quiet_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (!res_timing && !res_action));
endmodule

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;
  localparam int NT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [1:0]  cfg_mtype = '0;
  logic        cfg_sel = 1'b0, cfg_timing = 1'b0, cfg_action = 1'b0, cfg_chain = 1'b0;
  logic [63:0] cfg_value = '0;
  logic [NT-1:0] trig_en = '1;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [1:0]  evt_kind = '0;
  logic [63:0] evt_addr = '0, evt_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [NT-1:0] res_hitvec;
  logic        res_hit, res_timing, res_action;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dbg_trig_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_idx(cfg_idx),
    .cfg_mtype(cfg_mtype), .cfg_sel(cfg_sel), .cfg_timing(cfg_timing),
    .cfg_action(cfg_action), .cfg_chain(cfg_chain), .cfg_value(cfg_value),
    .trig_en(trig_en), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind), .evt_addr(evt_addr), .evt_data(evt_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_hitvec(res_hitvec),
    .res_hit(res_hit), .res_timing(res_timing), .res_action(res_action)
  );

  // Shadow of what the bench has programmed.
  logic        sh_arm [NT];
  logic [1:0]  sh_mt  [NT];
  logic        sh_sel [NT], sh_tim [NT], sh_act [NT], sh_ch [NT];
  logic [63:0] sh_val [NT];

  typedef struct {
    logic [NT-1:0] hv;
    logic          tim;
    logic          act;
    string         tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] trig_kind(input int i);
    if (i == 2 || i == 3 || i == 7) return 2'd2;
    if (i == 4 || i == 5 || i == 9) return 2'd1;
    return 2'd0;
  endfunction

  function automatic exp_t model(input logic [1:0] k, input logic [63:0] a,
                                 input logic [63:0] d, input string tag);
    exp_t e;
    logic [NT-1:0] m;
    m = '0;
    for (int i = 0; i < NT; i++) begin
      logic [63:0] op, msk;
      logic c;
      op  = sh_sel[i] ? d : a;
      msk = sh_val[i] ^ (sh_val[i] + 64'd1);
      case (sh_mt[i])
        2'd0: c = (op == sh_val[i]);
        2'd1: c = ((op | msk) == (sh_val[i] | msk));
        2'd2: c = (op >= sh_val[i]);
        default: c = (op < sh_val[i]);
      endcase
      m[i] = sh_arm[i] && trig_en[i] && (k == trig_kind(i)) &&
             !(trig_kind(i) == 2'd1 && sh_sel[i]) && c;
    end
    e.hv = '0;
    for (int g = 0; g < NT / 2; g++) begin
      if (sh_ch[2*g] && g != 1) begin
        e.hv[2*g]   = m[2*g] && m[2*g+1] && (sh_tim[2*g] == sh_tim[2*g+1]);
        e.hv[2*g+1] = e.hv[2*g];
      end else begin
        e.hv[2*g]   = m[2*g];
        e.hv[2*g+1] = m[2*g+1];
      end
    end
    e.tim = 1'b0;
    e.act = 1'b0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (e.hv[i]) begin
        e.tim = sh_tim[i];
        e.act = sh_act[i];
      end
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic put_cfg(input logic [3:0] idx, input logic [1:0] mt, input logic s,
                         input logic t, input logic ac, input logic ch, input logic [63:0] v);
    cfg_valid = 1'b1; cfg_idx = idx; cfg_mtype = mt; cfg_sel = s;
    cfg_timing = t; cfg_action = ac; cfg_chain = ch; cfg_value = v;
  endtask

  task automatic shadow(input logic [3:0] idx, input logic [1:0] mt, input logic s,
                        input logic t, input logic ac, input logic ch, input logic [63:0] v);
    if (idx < NT) begin
      sh_arm[idx] = 1'b1; sh_mt[idx] = mt; sh_sel[idx] = s;
      sh_tim[idx] = t; sh_act[idx] = ac; sh_ch[idx] = ch; sh_val[idx] = v;
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [1:0] mt, input logic s,
                    input logic t, input logic ac, input logic ch, input logic [63:0] v);
    @(posedge clk); #2;
    put_cfg(idx, mt, s, t, ac, ch, v);
    @(posedge clk); #2;
    cfg_valid = 1'b0;
    shadow(idx, mt, s, t, ac, ch, v);
  endtask

  // Driver: present an event, push the expected result when it is taken.
  task automatic send(input logic [1:0] k, input logic [63:0] a, input logic [63:0] d,
                      input string tag);
    @(posedge clk); #2;
    evt_valid = 1'b1; evt_kind = k; evt_addr = a; evt_data = d;
    do @(negedge clk); while (!evt_ready);
    sb.push_back(model(k, a, d, tag));
    @(posedge clk); #2;
    evt_valid = 1'b0;
  endtask

  // Write and event on the same edge: the event must see the old settings.
  task automatic wr_and_send(input logic [3:0] idx, input logic [1:0] mt,
                             input logic [63:0] v, input logic [1:0] k,
                             input logic [63:0] a, input string tag);
    @(posedge clk); #2;
    put_cfg(idx, mt, 1'b0, 1'b0, 1'b0, 1'b0, v);
    evt_valid = 1'b1; evt_kind = k; evt_addr = a; evt_data = '0;
    do @(negedge clk); while (!evt_ready);
    sb.push_back(model(k, a, 64'd0, tag));
    @(posedge clk); #2;
    evt_valid = 1'b0;
    cfg_valid = 1'b0;
    shadow(idx, mt, 1'b0, 1'b0, 1'b0, 1'b0, v);
  endtask

  // Monitor: pop and compare on each transfer.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (sb.size() == 0) begin
        check("R11 unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " hitvec"}, 64'(res_hitvec), 64'(e.hv));
        check({e.tag, " hit R10"}, 64'(res_hit), 64'(|e.hv));
        check({e.tag, " timing R10"}, 64'(res_timing), 64'(e.tim));
        check({e.tag, " action R10"}, 64'(res_action), 64'(e.act));
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      sh_arm[i] = 0; sh_mt[i] = 0; sh_sel[i] = 0; sh_tim[i] = 0;
      sh_act[i] = 0; sh_ch[i] = 0; sh_val[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_valid after reset", 64'(res_valid), 64'd0);
    check("R1 evt_ready after reset", 64'(evt_ready), 64'd1);

    send(2'd0, 64'd0, 64'd0, "R1 unprogrammed fetch");
    send(2'd2, 64'd0, 64'd0, "R1 unprogrammed store");

    wr(4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1000);
    send(2'd0, 64'h1000, 64'd0, "R3 equal hit");
    send(2'd0, 64'h1004, 64'd0, "R3 equal miss");
    send(2'd1, 64'h1000, 64'd0, "R4 wrong kind");

    wr(4'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 64'h500);
    send(2'd0, 64'd0, 64'h600, "R3 ge on data");
    send(2'd0, 64'd0, 64'h4ff, "R3 ge below");

    wr(4'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h30007);
    send(2'd1, 64'h3000c, 64'd0, "R3 masked hit");
    send(2'd1, 64'h30010, 64'd0, "R3 masked miss");

    wr(4'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h77);
    send(2'd1, 64'h77, 64'h77, "R5 load data never");

    wr(4'd9, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 64'h100);
    send(2'd1, 64'h30, 64'd0, "R10 lt load timing");
    send(2'd3, 64'h30, 64'd0, "R4 none kind");

    wr(4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1000);
    wr(4'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h800);
    send(2'd0, 64'h1000, 64'd0, "R7 linked both");
    send(2'd0, 64'h900, 64'd0, "R7 linked half");

    wr(4'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h800);
    send(2'd0, 64'h1000, 64'd0, "R8 timing split");

    wr(4'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h800);
    @(posedge clk); #2 trig_en[1] = 1'b0;
    send(2'd0, 64'h1000, 64'd0, "R6 disabled breaks link");
    @(posedge clk); #2 trig_en = '1; trig_en[4] = 1'b0;
    send(2'd1, 64'h3000c, 64'd0, "R6 disabled single");
    @(posedge clk); #2 trig_en = '1;

    wr(4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h40);
    wr(4'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h80);
    send(2'd2, 64'h40, 64'd0, "R9 store pair alone");
    send(2'd2, 64'h80, 64'd0, "R9 store odd member");

    wr(4'd7, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0);
    send(2'd2, 64'h80, 64'd0, "R10 lowest wins");

    wr(4'd10, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h9999);
    wr(4'd15, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h9999);
    send(2'd2, 64'h40, 64'd0, "R2 bad index ignored");

    wr_and_send(4'd2, 2'd0, 64'h44, 2'd2, 64'h44, "R2 same edge old cfg");
    send(2'd2, 64'h44, 64'd0, "R2 next event new cfg");

    // Back-pressure
    @(posedge clk); #2 res_ready = 1'b0;
    send(2'd0, 64'h1000, 64'd0, "R11 stalled result");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R11 valid held", 64'(res_valid), 64'd1);
    check("R11 ready low while full", 64'(evt_ready), 64'd0);
    check("R11 hitvec held", 64'(res_hitvec), 64'h3);
    @(posedge clk); #2 res_ready = 1'b1;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11 scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule